// File: doc/BRIEF.md
# Bridge Configuration-to-Special-Cycle Converter

This block sits inside a two-sided PCI-style bridge and looks at every request that enters from the primary side or the secondary side. Most requests go to a forward output unchanged, where the bridge's normal forwarding logic takes them. A Type 1 configuration write aimed at the broadcast encoding is different. Its device and function fields are all ones, its register field is zero, and its bus field names the bus on the far side. The block turns such a request into a Special Cycle on the far side. The Special Cycle has the same write data and a single data phase.

Each direction has a one-entry register stage with a valid/ready handshake. The register stage gives a latency of one cycle, and it holds its content while the downstream side stalls. A Special Cycle always ends in a master-abort, because no device claims it. The block watches the master-abort indication on each side. It sends a status set strobe for bit 13 only when the cycle last issued on that side was not a converted one.

Top module: `cfgsc_xlate`

## Requirements
- R1: An input request is converted when all of these hold. The command is configuration write (4'b1011). Address[1:0] is 2'b01 (Type 1). Address[15:11] is all ones. Address[10:8] is all ones. Address[7:2] is zero. Address[23:16] equals the far-side bus number. A converted request appears on the special-cycle channel of the far side with command 4'b0001 and the address unchanged.
- R2: A request whose address[15:11] is not all ones goes to the forward channel unchanged.
- R3: A request whose address[10:8] is not all ones goes to the forward channel unchanged.
- R4: A request whose address[7:2] is not zero goes to the forward channel unchanged.
- R5: Each direction uses its own bus number. A request entering on the primary side is compared against the secondary bus number. A request entering on the secondary side is compared against the primary bus number. On a mismatch the request is forwarded unchanged.
- R6: A converted request carries the input write data unmodified.
- R7: A converted request always leaves with a length of 1 data phase, whatever the input length. A forwarded request keeps its input length.
- R8: A request is never converted if its command is not configuration write (including configuration read, 4'b1010) or if address[1:0] is not 2'b01.
- R9: A request accepted at a clock edge is presented on an output after that same edge. While the selected output's ready is low, the output stays valid and unchanged, and the input ready is low.
- R10: A master-abort pulse on a side produces no status strobe when the last request handed off on that side was a converted one.
- R11: A master-abort pulse on a side drives that side's 16-bit status set mask to 16'h2000 (bit 13 only) on the following cycle when the last handed-off request was not converted. Without a master-abort pulse the mask is zero.
- R12: Once reset is released, both input readies are high, all output valids are low and both status masks are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_bus_num | input | 8 | Programmed primary bus number |
| sec_bus_num | input | 8 | Programmed secondary bus number |
| pin_valid | input | 1 | Request from the primary side is valid |
| pin_ready | output | 1 | Primary-side input can accept |
| pin_cmd | input | 4 | Primary-side command |
| pin_addr | input | 32 | Primary-side address |
| pin_data | input | 32 | Primary-side write data |
| pin_len | input | 4 | Primary-side data phase count |
| sin_valid | input | 1 | Request from the secondary side is valid |
| sin_ready | output | 1 | Secondary-side input can accept |
| sin_cmd | input | 4 | Secondary-side command |
| sin_addr | input | 32 | Secondary-side address |
| sin_data | input | 32 | Secondary-side write data |
| sin_len | input | 4 | Secondary-side data phase count |
| sout_sc_valid | output | 1 | Special Cycle to be issued on the secondary side |
| sout_sc_ready | input | 1 | Secondary special-cycle consumer ready |
| sout_fwd_valid | output | 1 | Forwarded request toward the secondary side |
| sout_fwd_ready | input | 1 | Secondary forward consumer ready |
| sout_cmd | output | 4 | Command toward the secondary side |
| sout_addr | output | 32 | Address toward the secondary side |
| sout_data | output | 32 | Data toward the secondary side |
| sout_len | output | 4 | Data phase count toward the secondary side |
| pout_sc_valid | output | 1 | Special Cycle to be issued on the primary side |
| pout_sc_ready | input | 1 | Primary special-cycle consumer ready |
| pout_fwd_valid | output | 1 | Forwarded request toward the primary side |
| pout_fwd_ready | input | 1 | Primary forward consumer ready |
| pout_cmd | output | 4 | Command toward the primary side |
| pout_addr | output | 32 | Address toward the primary side |
| pout_data | output | 32 | Data toward the primary side |
| pout_len | output | 4 | Data phase count toward the primary side |
| sec_mabort | input | 1 | Master-abort seen on the secondary side |
| pri_mabort | input | 1 | Master-abort seen on the primary side |
| sec_sts_set | output | 16 | Set mask for the secondary status register |
| pri_sts_set | output | 16 | Set mask for the primary status register |

## Verification
The assertions assume a few things about the inputs. The bus-number inputs stay constant while traffic flows. A master-abort pulse refers to the cycle most recently handed off on its side. An input request is held steady while its valid is high and ready is low. The stimulus programs the bus numbers once before reset release and never changes them. It drives each request at a falling edge and holds it until the input ready accepts it. It pulses a master-abort only after the preceding hand-off has drained from the scoreboard queue.

// File: rtl/cfgsc_pkg.sv
`timescale 1ns/1ps
package cfgsc_pkg;
  localparam int CMD_W  = 4;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 4;
  localparam int BUS_W  = 8;
  localparam int STS_W  = 16;
  localparam int MA_BIT = 13;

  localparam int BUS_HI = 23;
  localparam int BUS_LO = BUS_HI - BUS_W + 1;
  localparam int DEV_HI = 15;
  localparam int DEV_LO = 11;
  localparam int FN_HI  = 10;
  localparam int FN_LO  = 8;
  localparam int REG_HI = 7;
  localparam int REG_LO = 2;
  localparam int DEC_W  = BUS_HI + 1;

  localparam logic [CMD_W-1:0] CMD_CFG_WR  = 4'b1011;
  localparam logic [CMD_W-1:0] CMD_SPECIAL = 4'b0001;
  localparam logic [1:0]       KIND_TYPE1  = 2'b01;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [LEN_W-1:0]  len;
  } req_t;
endpackage

// File: rtl/cfgsc_decode.sv
`timescale 1ns/1ps
module cfgsc_decode
  import cfgsc_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  input  logic [DEC_W-1:0] addr_lo,
  input  logic [BUS_W-1:0] far_bus,
  output logic             hit
);
  logic is_wr, is_t1, dev_ok, fn_ok, reg_ok, bus_ok;

  always_comb begin
    is_wr  = (cmd == CMD_CFG_WR);
    is_t1  = (addr_lo[1:0] == KIND_TYPE1);
    dev_ok = &addr_lo[DEV_HI:DEV_LO];
    fn_ok  = &addr_lo[FN_HI:FN_LO];
    reg_ok = ~|addr_lo[REG_HI:REG_LO];
    bus_ok = (addr_lo[BUS_HI:BUS_LO] == far_bus);
    hit    = is_wr & is_t1 & dev_ok & fn_ok & reg_ok & bus_ok;
  end
endmodule

// File: rtl/cfgsc_stage.sv
`timescale 1ns/1ps
module cfgsc_stage
  import cfgsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] far_bus,
  input  logic             in_valid,
  output logic             in_ready,
  input  req_t             in_req,
  output logic             sc_valid,
  input  logic             sc_ready,
  output logic             fwd_valid,
  input  logic             fwd_ready,
  output req_t             out_req,
  output logic             fire,
  output logic             fire_sc
);
  logic vld_q, vld_d, sc_q, sc_d, hit, load, out_rdy;
  req_t req_q, req_d;

  cfgsc_decode u_decode (
    .cmd     (in_req.cmd),
    .addr_lo (in_req.addr[DEC_W-1:0]),
    .far_bus (far_bus),
    .hit     (hit)
  );

  always_comb begin
    out_rdy  = sc_q ? sc_ready : fwd_ready;
    in_ready = ~vld_q | out_rdy;
    load     = in_valid & in_ready;
    vld_d    = load | (vld_q & ~out_rdy);
    sc_d     = sc_q;
    req_d    = req_q;
    if (load) begin
      sc_d  = hit;
      req_d = in_req;
      if (hit) begin
        req_d.cmd = CMD_SPECIAL;
        req_d.len = LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sc_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      sc_q  <= sc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) req_q <= req_d;
  end

  assign sc_valid  = vld_q & sc_q;
  assign fwd_valid = vld_q & ~sc_q;
  assign out_req   = req_q;
  assign fire      = vld_q & out_rdy;
  assign fire_sc   = vld_q & out_rdy & sc_q;

  p_convert_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load && hit) |=> (sc_valid && out_req.cmd == CMD_SPECIAL));
  p_dev_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !(&in_req.addr[DEV_HI:DEV_LO])) |=> (fwd_valid && !sc_valid));
  p_reg_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (|in_req.addr[REG_HI:REG_LO])) |=> (fwd_valid && !sc_valid));
  p_data_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (out_req.data == $past(in_req.data)));
  p_sc_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && hit) |=> (out_req.len == LEN_W'(1)));
  p_fwd_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !hit) |=> (out_req.len == $past(in_req.len)));
  p_not_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && in_req.cmd != CMD_CFG_WR) |=> (fwd_valid && !sc_valid));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_rdy) |=> (vld_q && $stable(out_req) && $stable(sc_q)));
  p_stall_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_rdy) |-> !in_ready);
endmodule

// File: rtl/cfgsc_abort_mask.sv
`timescale 1ns/1ps
module cfgsc_abort_mask
  import cfgsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             fire_sc,
  input  logic             mabort,
  output logic [STS_W-1:0] sts_set
);
  logic last_sc_q, last_sc_d, set_q, set_d;

  always_comb begin
    last_sc_d = fire ? fire_sc : last_sc_q;
    set_d     = mabort & ~last_sc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_sc_q <= 1'b0;
      set_q     <= 1'b0;
    end else begin
      last_sc_q <= last_sc_d;
      set_q     <= set_d;
    end
  end

  assign sts_set = set_q ? (STS_W'(1) << MA_BIT) : '0;

  p_sc_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fire_sc) ##1 mabort |=> (sts_set == '0));
  p_fwd_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !fire_sc) ##1 mabort |=> (sts_set == (STS_W'(1) << MA_BIT)));
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mabort |=> (sts_set == '0));
endmodule

// File: rtl/cfgsc_xlate.sv
`timescale 1ns/1ps
module cfgsc_xlate
  import cfgsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  pri_bus_num,
  input  logic [BUS_W-1:0]  sec_bus_num,
  input  logic              pin_valid,
  output logic              pin_ready,
  input  logic [CMD_W-1:0]  pin_cmd,
  input  logic [ADDR_W-1:0] pin_addr,
  input  logic [DATA_W-1:0] pin_data,
  input  logic [LEN_W-1:0]  pin_len,
  input  logic              sin_valid,
  output logic              sin_ready,
  input  logic [CMD_W-1:0]  sin_cmd,
  input  logic [ADDR_W-1:0] sin_addr,
  input  logic [DATA_W-1:0] sin_data,
  input  logic [LEN_W-1:0]  sin_len,
  output logic              sout_sc_valid,
  input  logic              sout_sc_ready,
  output logic              sout_fwd_valid,
  input  logic              sout_fwd_ready,
  output logic [CMD_W-1:0]  sout_cmd,
  output logic [ADDR_W-1:0] sout_addr,
  output logic [DATA_W-1:0] sout_data,
  output logic [LEN_W-1:0]  sout_len,
  output logic              pout_sc_valid,
  input  logic              pout_sc_ready,
  output logic              pout_fwd_valid,
  input  logic              pout_fwd_ready,
  output logic [CMD_W-1:0]  pout_cmd,
  output logic [ADDR_W-1:0] pout_addr,
  output logic [DATA_W-1:0] pout_data,
  output logic [LEN_W-1:0]  pout_len,
  input  logic              sec_mabort,
  input  logic              pri_mabort,
  output logic [STS_W-1:0]  sec_sts_set,
  output logic [STS_W-1:0]  pri_sts_set
);
  logic [1:0] rst_sync_q;
  logic       rst_int;
  req_t       p_in, s_in, s_out, p_out;
  logic       s_fire, s_fire_sc, p_fire, p_fire_sc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int = rst_sync_q[1];

  assign p_in = '{cmd: pin_cmd, addr: pin_addr, data: pin_data, len: pin_len};
  assign s_in = '{cmd: sin_cmd, addr: sin_addr, data: sin_data, len: sin_len};

  // primary inbound -> issued on secondary; compared against secondary bus
  cfgsc_stage u_p2s (
    .clk (clk), .rst_n (rst_int), .far_bus (sec_bus_num),
    .in_valid (pin_valid), .in_ready (pin_ready), .in_req (p_in),
    .sc_valid (sout_sc_valid), .sc_ready (sout_sc_ready),
    .fwd_valid (sout_fwd_valid), .fwd_ready (sout_fwd_ready),
    .out_req (s_out), .fire (s_fire), .fire_sc (s_fire_sc)
  );

  // secondary inbound -> issued on primary; compared against primary bus
  cfgsc_stage u_s2p (
    .clk (clk), .rst_n (rst_int), .far_bus (pri_bus_num),
    .in_valid (sin_valid), .in_ready (sin_ready), .in_req (s_in),
    .sc_valid (pout_sc_valid), .sc_ready (pout_sc_ready),
    .fwd_valid (pout_fwd_valid), .fwd_ready (pout_fwd_ready),
    .out_req (p_out), .fire (p_fire), .fire_sc (p_fire_sc)
  );

  cfgsc_abort_mask u_sec_ma (
    .clk (clk), .rst_n (rst_int), .fire (s_fire), .fire_sc (s_fire_sc),
    .mabort (sec_mabort), .sts_set (sec_sts_set)
  );

  cfgsc_abort_mask u_pri_ma (
    .clk (clk), .rst_n (rst_int), .fire (p_fire), .fire_sc (p_fire_sc),
    .mabort (pri_mabort), .sts_set (pri_sts_set)
  );

  assign sout_cmd  = s_out.cmd;
  assign sout_addr = s_out.addr;
  assign sout_data = s_out.data;
  assign sout_len  = s_out.len;
  assign pout_cmd  = p_out.cmd;
  assign pout_addr = p_out.addr;
  assign pout_data = p_out.data;
  assign pout_len  = p_out.len;

  p_pri_bus_r5: assert property (@(posedge clk) disable iff (!rst_int)
    (pin_valid && pin_ready && pin_addr[BUS_HI:BUS_LO] != sec_bus_num) |=> !sout_sc_valid);
  p_sec_bus_r5: assert property (@(posedge clk) disable iff (!rst_int)
    (sin_valid && sin_ready && sin_addr[BUS_HI:BUS_LO] != pri_bus_num) |=> !pout_sc_valid);
  p_fn_field_r3: assert property (@(posedge clk) disable iff (!rst_int)
    (pin_valid && pin_ready && !(&pin_addr[FN_HI:FN_LO])) |=> !sout_sc_valid);
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_int)
    $rose(rst_int) |-> (!sout_sc_valid && !sout_fwd_valid && !pout_sc_valid && !pout_fwd_valid));
endmodule

// File: tb/test_cfgsc_xlate.sv
`timescale 1ns/1ps
module test_cfgsc_xlate;
  typedef struct {
    bit          sc;
    logic [3:0]  cmd;
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  len;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pri_bus_num = 8'h03;
  logic [7:0] sec_bus_num = 8'h05;
  logic pin_valid = 1'b0, sin_valid = 1'b0;
  logic [3:0] pin_cmd = '0, sin_cmd = '0, pin_len = '0, sin_len = '0;
  logic [31:0] pin_addr = '0, pin_data = '0, sin_addr = '0, sin_data = '0;
  logic sout_sc_ready = 1'b1, sout_fwd_ready = 1'b1;
  logic pout_sc_ready = 1'b1, pout_fwd_ready = 1'b1;
  logic sec_mabort = 1'b0, pri_mabort = 1'b0;
  logic pin_ready, sin_ready;
  logic sout_sc_valid, sout_fwd_valid, pout_sc_valid, pout_fwd_valid;
  logic [3:0] sout_cmd, pout_cmd, sout_len, pout_len;
  logic [31:0] sout_addr, sout_data, pout_addr, pout_data;
  logic [15:0] sec_sts_set, pri_sts_set;

  int checks = 0;
  int errors = 0;
  bit run_on = 1'b0;
  exp_t q_s[$];
  exp_t q_p[$];

  always #5 clk = ~clk;

  cfgsc_xlate i_cfgsc_xlate (.*);

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic compare(input bit sc, input logic [3:0] c, input logic [31:0] a,
                         input logic [31:0] d, input logic [3:0] l, inout exp_t q[$]);
    exp_t e;
    if (q.size() == 0) begin
      check(1'b0, "unexpected output item", {31'd0, sc}, 32'd0);
      return;
    end
    e = q.pop_front();
    check(sc == e.sc, {e.tag, " channel"}, {31'd0, sc}, {31'd0, e.sc});
    check(c == e.cmd, {e.tag, " cmd"}, {28'd0, c}, {28'd0, e.cmd});
    check(a == e.addr, {e.tag, " addr"}, a, e.addr);
    check(d == e.data, {e.tag, " data"}, d, e.data);
    check(l == e.len, {e.tag, " len"}, {28'd0, l}, {28'd0, e.len});
  endtask

  // monitors: a handshake completes at the next rising edge
  always @(negedge clk) begin
    if (run_on) begin
      if (sout_sc_valid && sout_sc_ready)   compare(1'b1, sout_cmd, sout_addr, sout_data, sout_len, q_s);
      if (sout_fwd_valid && sout_fwd_ready) compare(1'b0, sout_cmd, sout_addr, sout_data, sout_len, q_s);
      if (pout_sc_valid && pout_sc_ready)   compare(1'b1, pout_cmd, pout_addr, pout_data, pout_len, q_p);
      if (pout_fwd_valid && pout_fwd_ready) compare(1'b0, pout_cmd, pout_addr, pout_data, pout_len, q_p);
    end
  end

  function automatic exp_t expect_of(input bit sc, input logic [3:0] c, input logic [31:0] a,
                                     input logic [31:0] d, input logic [3:0] l, input string tag);
    exp_t e;
    e.sc = sc; e.addr = a; e.data = d; e.tag = tag;
    e.cmd = sc ? 4'b0001 : c;
    e.len = sc ? 4'd1 : l;
    return e;
  endfunction

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send_p(input bit sc, input logic [3:0] c, input logic [31:0] a,
                        input logic [31:0] d, input logic [3:0] l, input string tag);
    q_s.push_back(expect_of(sc, c, a, d, l, tag));
    pin_valid = 1'b1; pin_cmd = c; pin_addr = a; pin_data = d; pin_len = l;
    while (!pin_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    pin_valid = 1'b0;
  endtask

  task automatic send_s(input bit sc, input logic [3:0] c, input logic [31:0] a,
                        input logic [31:0] d, input logic [3:0] l, input string tag);
    q_p.push_back(expect_of(sc, c, a, d, l, tag));
    sin_valid = 1'b1; sin_cmd = c; sin_addr = a; sin_data = d; sin_len = l;
    while (!sin_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    sin_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_s.size() != 0 || q_p.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    check(pin_ready && sin_ready, "R12 input ready", {31'd0, pin_ready}, 32'd1);
    check(!(sout_sc_valid || sout_fwd_valid || pout_sc_valid || pout_fwd_valid),
          "R12 output valid", {31'd0, sout_sc_valid | sout_fwd_valid}, 32'd0);
    check(sec_sts_set == 16'h0 && pri_sts_set == 16'h0, "R12 status mask",
          {16'd0, sec_sts_set}, 32'd0);
    run_on = 1'b1;

    // primary side toward secondary (secondary bus 0x05)
    send_p(1'b1, 4'b1011, 32'h0005FF01, 32'hDEADBEEF, 4'd1, "R1 convert");
    send_p(1'b1, 4'b1011, 32'hA005FF01, 32'h12345678, 4'd4, "R6 R7 burst trimmed");
    send_p(1'b0, 4'b1011, 32'h0005F701, 32'h11111111, 4'd1, "R2 device field");
    send_p(1'b0, 4'b1011, 32'h0005FE01, 32'h22222222, 4'd2, "R3 function field");
    send_p(1'b0, 4'b1011, 32'h0005FF05, 32'h33333333, 4'd1, "R4 register field");
    send_p(1'b0, 4'b1011, 32'h0003FF01, 32'h44444444, 4'd1, "R5 primary bus mismatch");
    send_p(1'b0, 4'b1010, 32'h0005FF01, 32'h55555555, 4'd1, "R8 config read");
    send_p(1'b0, 4'b1011, 32'h0005FF00, 32'h66666666, 4'd3, "R8 type 0");
    send_p(1'b0, 4'b0111, 32'h0005FF01, 32'h77777777, 4'd4, "R7 R8 memory write len kept");

    // secondary side toward primary (primary bus 0x03)
    send_s(1'b1, 4'b1011, 32'h0003FF01, 32'hCAFEF00D, 4'd2, "R1 R5 secondary convert");
    send_s(1'b0, 4'b1011, 32'h0005FF01, 32'h88888888, 4'd1, "R5 secondary bus mismatch");
    drain();

    // R9 stall and hold
    sout_sc_ready = 1'b0; sout_fwd_ready = 1'b0;
    send_p(1'b0, 4'b1011, 32'h0005F701, 32'h99999999, 4'd5, "R9 held item");
    check(sout_fwd_valid, "R9 one-cycle latency", {31'd0, sout_fwd_valid}, 32'd1);
    check(!pin_ready, "R9 input ready low while stalled", {31'd0, pin_ready}, 32'd0);
    repeat (3) @(negedge clk);
    check(sout_fwd_valid && sout_addr == 32'h0005F701 && sout_data == 32'h99999999,
          "R9 held stable", sout_data, 32'h99999999);
    sout_sc_ready = 1'b1; sout_fwd_ready = 1'b1;
    drain();

    // R10/R11 secondary side master-abort masking
    send_p(1'b1, 4'b1011, 32'h0005FF01, 32'h0BADCAFE, 4'd1, "R10 sc before abort");
    drain();
    sec_mabort = 1'b1;
    @(negedge clk);
    sec_mabort = 1'b0;
    check(sec_sts_set == 16'h0000, "R10 secondary abort after sc", {16'd0, sec_sts_set}, 32'h0);
    send_p(1'b0, 4'b1011, 32'h0004FF01, 32'h0A0A0A0A, 4'd1, "R11 fwd before abort");
    drain();
    sec_mabort = 1'b1;
    @(negedge clk);
    sec_mabort = 1'b0;
    check(sec_sts_set == 16'h2000, "R11 secondary abort after fwd", {16'd0, sec_sts_set}, 32'h2000);
    @(negedge clk);
    check(sec_sts_set == 16'h0000, "R11 no abort no strobe", {16'd0, sec_sts_set}, 32'h0);

    // primary side master-abort masking
    send_s(1'b1, 4'b1011, 32'h0003FF01, 32'h5A5A5A5A, 4'd1, "R10 sc toward primary");
    drain();
    pri_mabort = 1'b1;
    @(negedge clk);
    pri_mabort = 1'b0;
    check(pri_sts_set == 16'h0000, "R10 primary abort after sc", {16'd0, pri_sts_set}, 32'h0);
    send_s(1'b0, 4'b1010, 32'h0003FF01, 32'hA5A5A5A5, 4'd1, "R11 fwd toward primary");
    drain();
    pri_mabort = 1'b1;
    @(negedge clk);
    pri_mabort = 1'b0;
    check(pri_sts_set == 16'h2000, "R11 primary abort after fwd", {16'd0, pri_sts_set}, 32'h2000);
    check(sec_sts_set == 16'h0000, "R11 other side untouched", {16'd0, sec_sts_set}, 32'h0);

    repeat (2) @(negedge clk);
    check(q_s.size() == 0 && q_p.size() == 0, "R9 all items delivered",
          q_s.size() + q_p.size(), 32'd0);
    finish_run();
  end
endmodule